// File: doc/BRIEF.md
# Programmable Interval Timer with Modulo Reload

This block gives a processor two time bases. The first is an 8-bit free-running divider. It advances on every clock and is zeroed by software. The second is an 8-bit counter that a prescaler advances once per selected period. When the counter wraps, it is refilled from a modulo register and a one-cycle interrupt pulse is raised.

Software reaches the four registers through a byte-wide port inside an I/O page. Reads are combinational and writes take effect at the clock edge. The interrupt pulse goes to the system interrupt controller.

Top module: `prog_timer`

## Requirements
- R1: After a synchronous active-low reset, all four registers read 0x00 and `timer_irq` is low.
- R2: The divider at offset 0x04 increases by one every clock and wraps from 0xFF to 0x00. Any write to offset 0x04 zeroes it, whatever the written data.
- R3: The counter (offset 0x05) and the modulo value (offset 0x06) read back what was written. The control register (offset 0x07) keeps bits 2:0 and reads bits 7:3 as zero. Any unmapped offset reads 0x00.
- R4: Control bit 2 runs the counter, and bits 1:0 set the period: 00 gives 16 clocks, 01 gives 64, 10 gives 256 and 11 gives 1024. The first increment lands exactly one period after the edge of the enabling write, and later increments follow every period.
- R5: An increment while the counter holds 0xFF loads the modulo value instead. `timer_irq` is high for exactly one cycle, the same cycle in which the reloaded value first reads back.
- R6: While bit 2 is clear, the counter holds its value and `timer_irq` stays low. The prescaler is also held cleared, so re-enabling waits one full period.
- R7: A counter write on the same edge as an increment wins: the written value is stored, no interrupt is raised, and the prescaler phase is kept.
- R8: If a control write shortens the period below the prescale count already reached, the increment happens on the next edge. Full periods follow after that. A control write that keeps bit 2 set does not restart the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | Write strobe, sampled at the clock edge |
| cpu_addr | input | 8 | Register offset within the I/O page |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for `cpu_addr`, combinational |
| timer_irq | output | 1 | One-cycle interrupt request on counter wrap |

## Verification
The hardest cases are the ones that depend on prescaler phase, which cannot be read from the ports: a counter write landing on the very edge of an increment, and a period cut below the count already reached. The bench disables the timer first, which clears the prescaler. It then counts clock edges from the enabling write, so it knows exactly which edge carries each increment. It places the colliding write on that edge, and it issues the period change at a known prescale count. Overflow is reached by preloading 0xFF or 0xFE rather than waiting through 256 increments.

// File: rtl/ptmr_pkg.sv
// Shared offsets and types for the programmable timer.
// Assumes an I/O page addressed by a byte offset.
package ptmr_pkg;
    localparam int unsigned OFS_DIV = 4;
    localparam int unsigned OFS_CNT = 5;
    localparam int unsigned OFS_MOD = 6;
    localparam int unsigned OFS_CTL = 7;

    typedef struct packed {
        logic       run;   // bit 2
        logic [1:0] rate;  // bits 1:0
    } ctl_t;
endpackage

// File: rtl/ptmr_divider.sv
// Free-running divider: adds one every clock and is zeroed by a write.
// Assumes clr is a single-cycle strobe from the register decode.
module ptmr_divider #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] div
);
    logic [W-1:0] div_q;

    // Advance the divider, or zero it on a write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) div_q <= '0;
        else               div_q <= div_q + 1'b1;
    end

    assign div = div_q;

    AST_DIV_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> div == '0); // R2
    AST_DIV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> div == W'($past(div) + 1'b1)); // R2
endmodule

// File: rtl/ptmr_prescaler.sv
// Prescaler: counts clocks while running and emits one tick per selected
// period (BASE_PERIOD times 4 to the power of rate). Held at zero while
// stopped. Uses a >= compare, so a shortened period ticks at once.
module ptmr_prescaler #(
    parameter int unsigned BASE_PERIOD = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    localparam int unsigned PERIOD_MAX = BASE_PERIOD * 64;
    localparam int unsigned PRE_W      = $clog2(PERIOD_MAX);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   limit;

    // Period in clocks for the selected rate.
    always_comb limit = (PRE_W+1)'(BASE_PERIOD) << {rate, 1'b0};

    // Tick once the count reaches the last clock of the period.
    always_comb tick = run && ({1'b0, pre_q} >= (limit - 1'b1));

    // Count while running; clear on a tick or while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)           pre_q <= '0;
        else if (!run || tick) pre_q <= '0;
        else                  pre_q <= pre_q + 1'b1;
    end

    AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick); // R6
    AST_PRE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        run && !tick |=> pre_q == PRE_W'($past(pre_q) + 1'b1)); // R4
endmodule

// File: rtl/ptmr_counter.sv
// Counter with modulo reload. Increments on tick; at all-ones it loads the
// modulo value and pulses irq for one cycle. A counter write beats a tick.
module ptmr_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_cnt,
    input  logic         wr_mod,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt,
    output logic [W-1:0] modv,
    output logic         irq
);
    logic [W-1:0] cnt_q, mod_q;
    logic         irq_q;
    logic         wrap;

    // Overflow when a tick finds the counter full and no write overrides it.
    always_comb wrap = tick && !wr_cnt && (cnt_q == {W{1'b1}});

    // Counter update: write first, then reload on wrap, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wr_cnt) cnt_q <= wdata;
        else if (wrap)   cnt_q <= mod_q;
        else if (tick)   cnt_q <= cnt_q + 1'b1;
    end

    // Modulo register, written only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)      mod_q <= '0;
        else if (wr_mod) mod_q <= wdata;
    end

    // One-cycle interrupt pulse after a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= wrap;
    end

    assign cnt  = cnt_q;
    assign modv = mod_q;
    assign irq  = irq_q;

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R5
    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cnt == $past(mod_q)); // R5
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt == $past(wdata)) && !irq); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !wr_cnt |=> $stable(cnt)); // R6
endmodule

// File: rtl/prog_timer.sv
// Programmable timer top: register decode, control register, read mux and
// the three datapath pieces. Reads are combinational, writes land at the
// edge. Assumes one access per cycle on a byte offset within the I/O page.
module prog_timer #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned BASE_PERIOD = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              timer_irq
);
    import ptmr_pkg::*;

    localparam int unsigned CTL_W = $bits(ctl_t);

    logic        hit_div, hit_cnt, hit_mod, hit_ctl;
    ctl_t        ctl_q;
    logic        tick;
    logic [DATA_W-1:0] div_v, cnt_v, mod_v;

    // Offset decode.
    always_comb begin
        hit_div = cpu_addr == ADDR_W'(OFS_DIV);
        hit_cnt = cpu_addr == ADDR_W'(OFS_CNT);
        hit_mod = cpu_addr == ADDR_W'(OFS_MOD);
        hit_ctl = cpu_addr == ADDR_W'(OFS_CTL);
    end

    // Control register: keeps the low bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)                ctl_q <= '0;
        else if (cpu_wr && hit_ctl) ctl_q <= ctl_t'(cpu_wdata[CTL_W-1:0]);
    end

    ptmr_divider #(.W(DATA_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cpu_wr && hit_div),
        .div  (div_v)
    );

    ptmr_prescaler #(.BASE_PERIOD(BASE_PERIOD)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (ctl_q.run),
        .rate (ctl_q.rate),
        .tick (tick)
    );

    ptmr_counter #(.W(DATA_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .wr_cnt(cpu_wr && hit_cnt),
        .wr_mod(cpu_wr && hit_mod),
        .wdata (cpu_wdata),
        .cnt   (cnt_v),
        .modv  (mod_v),
        .irq   (timer_irq)
    );

    // Read mux; unmapped offsets return zero.
    always_comb begin
        cpu_rdata = '0;
        if (hit_div)      cpu_rdata = div_v;
        else if (hit_cnt) cpu_rdata = cnt_v;
        else if (hit_mod) cpu_rdata = mod_v;
        else if (hit_ctl) cpu_rdata = DATA_W'(ctl_q);
    end

    AST_IRQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        timer_irq |-> $past(ctl_q.run)); // R6
    AST_CTL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ctl |-> cpu_rdata[DATA_W-1:CTL_W] == '0); // R3
endmodule

// File: tb/prog_timer_test.sv
module prog_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_addr = 8'h00;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       timer_irq;

    int n_chk = 0;
    int n_fail = 0;
    int irq_seen = 0;

    localparam logic [7:0] A_DIV = 8'h04, A_CNT = 8'h05, A_MOD = 8'h06, A_CTL = 8'h07;

    prog_timer uut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .timer_irq(timer_irq)
    );

    always #5 clk = ~clk;

    always @(negedge clk) if (timer_irq) irq_seen++;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Called just after a negedge; the write lands on the next posedge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        cpu_addr = a;
        #1;
        v = int'(cpu_rdata);
    endtask

    task automatic t_reset();
        int v;
        rd(A_DIV, v); chk("R1 div", v, 0);
        rd(A_CNT, v); chk("R1 cnt", v, 0);
        rd(A_MOD, v); chk("R1 mod", v, 0);
        rd(A_CTL, v); chk("R1 ctl", v, 0);
        chk("R1 irq", int'(timer_irq), 0);
    endtask

    task automatic t_divider();
        int v;
        wr(A_DIV, 8'hA5);
        rd(A_DIV, v); chk("R2 cleared", v, 0);
        repeat (10) @(negedge clk);
        rd(A_DIV, v); chk("R2 step", v, 10);
        repeat (246) @(negedge clk);
        rd(A_DIV, v); chk("R2 wrap", v, 0);
    endtask

    task automatic t_regs();
        int v;
        wr(A_CNT, 8'h5A); rd(A_CNT, v); chk("R3 cnt rw", v, 'h5A);
        wr(A_MOD, 8'hC3); rd(A_MOD, v); chk("R3 mod rw", v, 'hC3);
        wr(A_CTL, 8'hFB); rd(A_CTL, v); chk("R3 ctl mask", v, 'h03);
        wr(A_CTL, 8'h00);
        rd(8'h08, v); chk("R3 unmapped", v, 0);
    endtask

    task automatic t_period(input logic [1:0] sel, input int per);
        int v;
        wr(A_CTL, 8'h00);
        wr(A_CNT, 8'h00);
        wr(A_CTL, {5'b0, 1'b1, sel});
        repeat (per - 1) @(negedge clk);
        rd(A_CNT, v); chk("R4 before first", v, 0);
        @(negedge clk);
        rd(A_CNT, v); chk("R4 first", v, 1);
        repeat (per - 1) @(negedge clk);
        rd(A_CNT, v); chk("R4 before second", v, 1);
        @(negedge clk);
        rd(A_CNT, v); chk("R4 second", v, 2);
    endtask

    task automatic t_overflow();
        int v;
        wr(A_CTL, 8'h00);
        wr(A_MOD, 8'hF0);
        wr(A_CNT, 8'hFE);
        irq_seen = 0;
        wr(A_CTL, 8'h04);
        repeat (31) @(negedge clk);
        rd(A_CNT, v); chk("R5 full", v, 'hFF);
        chk("R5 irq low before", int'(timer_irq), 0);
        @(negedge clk);
        rd(A_CNT, v); chk("R5 reload", v, 'hF0);
        chk("R5 irq high", int'(timer_irq), 1);
        @(negedge clk);
        chk("R5 irq one cycle", int'(timer_irq), 0);
        chk("R5 irq count", irq_seen, 1);
    endtask

    task automatic t_disable();
        int v;
        wr(A_CTL, 8'h00);
        wr(A_MOD, 8'h77);
        wr(A_CNT, 8'h20);
        wr(A_CTL, 8'h04);
        repeat (20) @(negedge clk);
        wr(A_CTL, 8'h00);
        repeat (500) @(negedge clk);
        rd(A_CNT, v); chk("R6 hold", v, 'h21);
        wr(A_CNT, 8'hFF);
        irq_seen = 0;
        repeat (300) @(negedge clk);
        rd(A_CNT, v); chk("R6 hold full", v, 'hFF);
        chk("R6 no irq", irq_seen, 0);
        wr(A_CTL, 8'h04);
        repeat (15) @(negedge clk);
        rd(A_CNT, v); chk("R6 restart full period", v, 'hFF);
        @(negedge clk);
        rd(A_CNT, v); chk("R6 reload after reenable", v, 'h77);
    endtask

    task automatic t_write_wins();
        int v;
        wr(A_CTL, 8'h00);
        wr(A_CNT, 8'hFF);
        wr(A_MOD, 8'h33);
        irq_seen = 0;
        wr(A_CTL, 8'h04);
        repeat (15) @(negedge clk);
        wr(A_CNT, 8'h10);
        rd(A_CNT, v); chk("R7 write wins", v, 'h10);
        chk("R7 no irq", irq_seen, 0);
        repeat (15) @(negedge clk);
        rd(A_CNT, v); chk("R7 phase kept before", v, 'h10);
        @(negedge clk);
        rd(A_CNT, v); chk("R7 phase kept", v, 'h11);
    endtask

    task automatic t_shorten();
        int v;
        wr(A_CTL, 8'h00);
        wr(A_CNT, 8'h40);
        wr(A_CTL, 8'h07);
        repeat (99) @(negedge clk);
        wr(A_CTL, 8'h04);
        rd(A_CNT, v); chk("R8 no tick yet", v, 'h40);
        @(negedge clk);
        rd(A_CNT, v); chk("R8 immediate tick", v, 'h41);
        repeat (15) @(negedge clk);
        rd(A_CNT, v); chk("R8 full period before", v, 'h41);
        @(negedge clk);
        rd(A_CNT, v); chk("R8 full period", v, 'h42);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_divider();
        t_regs();
        t_period(2'b00, 16);
        t_period(2'b01, 64);
        t_period(2'b10, 256);
        t_period(2'b11, 1024);
        t_overflow();
        t_disable();
        t_write_wins();
        t_shorten();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule